// File: doc/BRIEF.md
# Loadable Synchronous Up-Counter with Dual Enables

This block is a four-bit synchronous binary up-counter. It has an active-low asynchronous clear, an active-low synchronous parallel load and two count-enable inputs. Both enables must be high for the count to advance. The clear takes priority over everything else. The load takes priority over the enables, and the enables only decide between holding and counting.

A combinational ripple-carry output goes high when the count is all ones and the carry enable is high. This lets several stages be chained: each stage's carry drives the carry enable of the next stage, and all stages share one clock. Surrounding logic can decode a terminal count and drive the load input from it. The counter then reloads a start value and runs through a shorter cycle.

Top module: `lcnt_counter`

## Requirements
- R1: While `clr_n` is low, `count` is 0000. It goes to 0000 as soon as `clr_n` falls, without waiting for a clock edge, and this overrides load and enables.
- R2: With `clr_n` high and `load_n` low, the next rising clock edge copies `par_in` into `count`, bit for bit (`par_in[0]` goes to `count[0]`, the least significant bit). This happens whatever the values of `cnt_en` and `carry_en`.
- R3: With `clr_n` and `load_n` high and at least one of `cnt_en` and `carry_en` low, `count` keeps its value across the rising edge.
- R4: With `clr_n`, `load_n`, `cnt_en` and `carry_en` all high, each rising edge adds one to `count`.
- R5: Counting from 1111 gives 0000 on the next edge.
- R6: `carry_out` is high exactly when `count` is 1111 and `carry_en` is high, independent of `cnt_en` and `load_n`. It follows `carry_en` with no clock edge in between.
- R7: If surrounding logic drives `load_n` low whenever `count` is 0111 and presents 0000 on `par_in`, the counter repeats the eight states 0000 to 0111 and never leaves them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable that does not gate the carry |
| carry_en | input | 1 | Count enable that also gates the carry |
| par_in | input | 4 | Parallel load value, bit 0 least significant |
| count | output | 4 | Present count, bit 0 least significant |
| carry_out | output | 1 | Ripple carry: all ones AND `carry_en` |

## Verification
The hardest case to reach is a clear that arrives between clock edges. The bench first counts up to a nonzero value. It then drops `clr_n` a few nanoseconds after a falling edge and samples `count` before the next rising edge. This shows that the clear did not wait for the clock. The combinational carry path is exercised in the same way: the bench parks the count at 1111 and toggles `carry_en` mid-cycle. The bench also wraps its own decoder around the ports, closing the load feedback at 0111 to confirm the eight-state cycle.

// File: rtl/lcnt_pkg.sv
// Package: shared types for the loadable counter.
// Assumes nothing beyond IEEE 1800-2017.
package lcnt_pkg;
    // Operation chosen for the next synchronous edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2
    } lcnt_op_e;
endpackage

// File: rtl/lcnt_mode_dec.sv
// Module: lcnt_mode_dec
// Picks the synchronous operation by priority: a load beats counting,
// and counting needs both enables. Assumes that the asynchronous clear
// is handled at the register and not here.
module lcnt_mode_dec
    import lcnt_pkg::*;
(
    input  logic     load_n,
    input  logic     cnt_en,
    input  logic     carry_en,
    output lcnt_op_e op
);
    // Priority decode of load over enables.
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (cnt_en && carry_en)
            op = OP_INC;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/lcnt_next.sv
// Module: lcnt_next
// Computes the next count value for the chosen operation. The increment
// wraps modulo 2**WIDTH. Assumes that op is one of the three encoded values.
module lcnt_next
    import lcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  lcnt_op_e         op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Next-state selection.
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = load_val;
            OP_INC:  nxt = cur + ONE;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/lcnt_carry.sv
// Module: lcnt_carry
// Ripple-carry term: an AND chain across all count bits, gated by the
// carry enable. It is purely combinational. Assumes WIDTH >= 1.
module lcnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             carry_en,
    output logic             carry_out
);
    logic [WIDTH:0] chain;

    assign chain[0] = carry_en;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_and
            // One stage of the AND chain.
            assign chain[i+1] = chain[i] & cur[i];
        end
    endgenerate

    assign carry_out = chain[WIDTH];
endmodule

// File: rtl/lcnt_counter.sv
// Module: lcnt_counter (top)
// Loadable synchronous up-counter with an asynchronous active-low clear,
// a synchronous active-low load, two count enables and a ripple carry.
// Assumes that all cascaded stages share clk and that par_in is stable
// around the rising edge.
module lcnt_counter
    import lcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             carry_en,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO     = '0;

    lcnt_op_e         op;
    logic [WIDTH-1:0] nxt;

    lcnt_mode_dec u_dec (
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .carry_en (carry_en),
        .op       (op)
    );

    lcnt_next #(.WIDTH(WIDTH)) u_next (
        .op       (op),
        .cur      (count),
        .load_val (par_in),
        .nxt      (nxt)
    );

    lcnt_carry #(.WIDTH(WIDTH)) u_carry (
        .cur       (count),
        .carry_en  (carry_en),
        .carry_out (carry_out)
    );

    // Count register: the clear acts at once, otherwise update on the edge.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            count <= ZERO;
        else
            count <= nxt;
    end

    // R1
    clear_zero_chk: assert property (@(negedge clk)
        !clr_n |-> count == ZERO);

    // R2
    load_apply_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> count == $past(par_in));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && carry_en)) |=> $stable(count));

    // R4
    inc_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && carry_en) |=> count == $past(count) + WIDTH'(1));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && carry_en && count == ALL_ONES) |=> count == ZERO);

    // R6
    carry_term_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (count == ALL_ONES && carry_en));

    // R6
    carry_present_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (count == ALL_ONES && carry_en) |-> carry_out);
endmodule

// File: tb/lcnt_counter_bench.sv
`timescale 1ns/1ps
module lcnt_counter_bench;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load_n = 1'b1;
    logic       cnt_en = 1'b0;
    logic       carry_en = 1'b0;
    logic [3:0] par_in = 4'd0;
    logic [3:0] count;
    logic       carry_out;

    int checks = 0;
    int fails  = 0;
    int ref_q  = 0;

    always #5 clk = ~clk;

    lcnt_counter u_lcnt_counter (
        .clk       (clk),
        .clr_n     (clr_n),
        .load_n    (load_n),
        .cnt_en    (cnt_en),
        .carry_en  (carry_en),
        .par_in    (par_in),
        .count     (count),
        .carry_out (carry_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: apply inputs, update the model at the rising edge, compare at the falling edge.
    task automatic cycle(input bit c, input bit l, input bit p, input bit t, input int d);
        string tag;
        clr_n = c; load_n = l; cnt_en = p; carry_en = t; par_in = d[3:0];
        @(posedge clk);
        if (!c)          begin tag = "R1"; ref_q = 0; end
        else if (!l)     begin tag = "R2"; ref_q = d % 16; end
        else if (p && t) begin tag = (ref_q == 15) ? "R5" : "R4"; ref_q = (ref_q + 1) % 16; end
        else             tag = "R3";
        @(negedge clk);
        check(tag, count, ref_q);
        check("R6", carry_out, (ref_q == 15 && t) ? 1 : 0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog (all requirements) actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Reset state.
        cycle(0, 1, 1, 1, 9);
        cycle(0, 0, 1, 1, 9);
        // Count up across the full range, including the wrap.
        for (int i = 0; i < 18; i++) cycle(1, 1, 1, 1, 0);
        // Hold with each enable low.
        cycle(1, 1, 0, 1, 0);
        cycle(1, 1, 1, 0, 0);
        cycle(1, 1, 0, 0, 0);
        // Load with the enables low and high.
        cycle(1, 0, 0, 0, 4'hA);
        cycle(1, 0, 1, 1, 4'h3);
        cycle(1, 0, 0, 1, 4'hF);
        // Carry gating: count 1111, carry_en low, then cnt_en low.
        cycle(1, 1, 1, 0, 0);
        cycle(1, 1, 0, 1, 0);
        // R6: carry follows carry_en mid-cycle with no clock edge.
        carry_en = 1'b0; #1;
        check("R6", carry_out, 0);
        carry_en = 1'b1; #1;
        check("R6", carry_out, 1);
        load_n = 1'b0; cnt_en = 1'b0; #1;
        check("R6", carry_out, 1);
        // R1: clear between edges, sampled before the next rising edge.
        cycle(1, 0, 0, 0, 4'h6);
        clr_n = 1'b0; #2;
        check("R1", count, 0);
        ref_q = 0;
        cycle(0, 0, 1, 1, 4'h5);
        // R7: decode 0111, load 0000, check the eight-state cycle.
        for (int i = 0; i < 24; i++) begin
            cycle(1, (ref_q == 7) ? 0 : 1, 1, 1, 0);
            check("R7", (count <= 7) ? 1 : 0, 1);
        end
        // Run through the full sequence once more with patterned loads.
        for (int i = 0; i < 16; i++) cycle(1, (i % 5 == 0) ? 0 : 1, 1, (i % 3 != 0), (i * 7) % 16);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule